// File: doc/BRIEF.md
# Watchdog Timer with Reset-Reason Capture

This block is a system watchdog. A down-counter runs on a slow reference clock. Software sets it up and services it through three word registers on the bus clock. A software write arms the watchdog, and no later write can disarm it. Once armed, the counter must be reloaded regularly with a fixed key value. If it is not, the counter runs down and the block raises a sticky expiry output. The external reset generator uses that output.

A two-bit reset-reason register sits in the bus domain. It records whether the last reset came from the external pin or from watchdog expiry. It keeps its value through a bus-side reset, so software can read the cause after the system restarts. Software clears it by writing to its offset.

A reload request crosses from the bus clock to the reference clock as a toggle through a two-flop synchroniser, so no kick is lost. The arm bit crosses the same way. The expiry flag and the pin reset enter the bus domain through the same kind of synchroniser.

Top module: `watchdog_ctrl`

## Requirements
- R1: A bus reset (`rst` high) disarms the watchdog and returns the reload register to 32768. It leaves the reset-reason register unchanged. After it, offset 0x0 reads 32768 and offset 0x4 reads 0.
- R2: Holding `pin_rst_n` low sets the reference-domain counter to 32768 and drops `expired_o`. It also sets the reason register to 2'b01 (pin reset).
- R3: Offset 0x0 holds the reload value in bits [COUNT_W-1:0]. Writes change it only while the watchdog is disarmed. Once armed, writes leave it as it was.
- R4: Writing offset 0x4 with bit 31 set arms the watchdog and requests a reload. Bit 31 of offset 0x4 reads back the armed state. No write clears it.
- R5: While armed, a write to offset 0x4 with bits [15:0] equal to 0x6699 requests a reload. Any other value in bits [15:0] has no effect. A key write while disarmed neither arms nor reloads.
- R6: On each reference-clock edge with no reload pending, the counter decrements by one if the watchdog is armed and `stop_i` is low. While `stop_i` is high, the counter holds.
- R7: Every reload request reaches the reference domain through the toggle synchroniser. It loads the counter even while `stop_i` is high.
- R8: `expired_o` rises on the reference edge after the count reaches 1 while armed. It then stays high until the next pin reset, even through a bus reset. With a freshly loaded value N, this happens about N+3 reference edges after the write.
- R9: When the synchronised expiry rises, the reason register becomes 2'b11 on the third bus edge after `expired_o` rises. The value 2'b10 never appears.
- R10: Any write to offset 0x8 clears the reason register to 2'b00. A clear that falls on the same bus edge as the expiry capture loses to the capture.
- R11: Read data is registered, one cycle after the address. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high bus reset |
| ref_clk | input | 1 | Reference clock that drives the counter |
| pin_rst_n | input | 1 | External reset pin, active low, synchronous to ref_clk |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data for addr_i |
| stop_i | input | 1 | Freezes the countdown while high |
| expired_o | output | 1 | Sticky watchdog expiry |

## Verification
The collision that matters is a software clear of the reason register landing on the same bus edge as the capture of a fresh expiry. The bench uses a reference clock whose edges never coincide with bus edges. It locates the rise of `expired_o`, then repeats the run five times, moving a single clear write from the first to the fifth bus edge after that rise. Clears on edges one to three must leave 2'b11, and later clears must leave 2'b00. A second overlap, a kick arriving while `stop_i` freezes the counter, is judged by how long the counter runs to expiry after the freeze is released.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned OFS_COUNT  = 32'h0;
  localparam int unsigned OFS_CTRL   = 32'h4;
  localparam int unsigned OFS_REASON = 32'h8;

  localparam logic [15:0] KICK_KEY = 16'h6699;

  typedef enum logic [1:0] {
    RR_NONE = 2'b00,
    RR_PIN  = 2'b01,
    RR_WDOG = 2'b11
  } reason_e;
endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk) begin
    ff_q[0] <= d_i;
    for (int i = 1; i < STAGES; i++) ff_q[i] <= ff_q[i-1];
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/wdog_bus_regs.sv
module wdog_bus_regs #(
  parameter int          COUNT_W     = 16,
  parameter int unsigned RESET_COUNT = 32768,
  parameter int          ADDR_W      = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  input  logic [1:0]         reason_i,
  output logic [31:0]        rdata_o,
  output logic               armed_o,
  output logic [COUNT_W-1:0] reload_val_o,
  output logic               reload_tgl_o,
  output logic               reason_clr_o
);
  import wdog_pkg::*;

  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_RSN  = ADDR_W'(OFS_REASON);

  logic               armed_q;
  logic [COUNT_W-1:0] reload_q;
  logic               tgl_q;
  logic [31:0]        rd_q, rd_d;
  logic               wr_cnt, wr_ctrl, kick_req;

  assign wr_cnt   = wr_en_i && (addr_i == A_CNT);
  assign wr_ctrl  = wr_en_i && (addr_i == A_CTRL);
  assign kick_req = wr_ctrl && (wdata_i[31] || (armed_q && wdata_i[15:0] == KICK_KEY));

  always_comb begin
    case (addr_i)
      A_CNT:   rd_d = 32'(reload_q);
      A_CTRL:  rd_d = {armed_q, 31'b0};
      A_RSN:   rd_d = {30'b0, reason_i};
      default: rd_d = 32'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q  <= 1'b0;
      reload_q <= COUNT_W'(RESET_COUNT);
      tgl_q    <= 1'b0;
      rd_q     <= 32'b0;
    end else begin
      if (wr_cnt && !armed_q) reload_q <= wdata_i[COUNT_W-1:0];
      if (wr_ctrl && wdata_i[31]) armed_q <= 1'b1;
      if (kick_req) tgl_q <= ~tgl_q;
      rd_q <= rd_d;
    end
  end

  assign rdata_o      = rd_q;
  assign armed_o      = armed_q;
  assign reload_val_o = reload_q;
  assign reload_tgl_o = tgl_q;
  assign reason_clr_o = wr_en_i && (addr_i == A_RSN);
endmodule

// File: rtl/wdog_ref_cnt.sv
module wdog_ref_cnt #(
  parameter int          COUNT_W     = 16,
  parameter int unsigned RESET_COUNT = 32768,
  parameter int          SYNC_STAGES = 2
) (
  input  logic               ref_clk,
  input  logic               pin_rst_n,
  input  logic               armed_i,
  input  logic               reload_tgl_i,
  input  logic [COUNT_W-1:0] reload_val_i,
  input  logic               stop_i,
  output logic               expired_o,
  output logic [COUNT_W-1:0] cnt_o,
  output logic               load_o
);
  logic               armed_s, tgl_s, tgl_prev_q;
  logic [COUNT_W-1:0] cnt_q;
  logic               exp_q;
  logic               load;

  wdog_sync #(.STAGES(SYNC_STAGES)) u_arm_sync (.clk(ref_clk), .d_i(armed_i),      .q_o(armed_s));
  wdog_sync #(.STAGES(SYNC_STAGES)) u_tgl_sync (.clk(ref_clk), .d_i(reload_tgl_i), .q_o(tgl_s));

  assign load = tgl_s ^ tgl_prev_q;

  always_ff @(posedge ref_clk) begin
    if (!pin_rst_n) begin
      cnt_q      <= COUNT_W'(RESET_COUNT);
      exp_q      <= 1'b0;
      tgl_prev_q <= tgl_s;
    end else begin
      tgl_prev_q <= tgl_s;
      if (load)
        cnt_q <= reload_val_i;
      else if (armed_s && !stop_i && cnt_q != '0)
        cnt_q <= cnt_q - COUNT_W'(1);
      if (armed_s && cnt_q == COUNT_W'(1)) exp_q <= 1'b1;
    end
  end

  assign expired_o = exp_q;
  assign cnt_o     = cnt_q;
  assign load_o    = load;
endmodule

// File: rtl/wdog_reason.sv
module wdog_reason #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       pin_rst_n,
  input  logic       expired_i,
  input  logic       clr_i,
  output logic [1:0] reason_o,
  output logic       pin_ok_o,
  output logic       exp_rise_o
);
  import wdog_pkg::*;

  logic    pin_s, exp_s, exp_prev_q;
  reason_e reason_q;

  wdog_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (.clk(clk), .d_i(pin_rst_n), .q_o(pin_s));
  wdog_sync #(.STAGES(SYNC_STAGES)) u_exp_sync (.clk(clk), .d_i(expired_i), .q_o(exp_s));

  assign exp_rise_o = exp_s && !exp_prev_q;

  always_ff @(posedge clk) begin
    exp_prev_q <= exp_s;
    if (!pin_s)          reason_q <= RR_PIN;
    else if (exp_rise_o) reason_q <= RR_WDOG;
    else if (clr_i)      reason_q <= RR_NONE;
  end

  assign reason_o = reason_q;
  assign pin_ok_o = pin_s;
endmodule

// File: rtl/watchdog_ctrl.sv
module watchdog_ctrl #(
  parameter int          COUNT_W     = 16,
  parameter int unsigned RESET_COUNT = 32768,
  parameter int          ADDR_W      = 4,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_clk,
  input  logic              pin_rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              stop_i,
  output logic              expired_o
);
  logic               armed_w, tgl_w, clr_w, load_w, pin_ok_w, exp_rise_w;
  logic [COUNT_W-1:0] reload_w, cnt_w;
  logic [1:0]         reason_w;

  wdog_bus_regs #(.COUNT_W(COUNT_W), .RESET_COUNT(RESET_COUNT), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .reason_i(reason_w), .rdata_o(rdata_o), .armed_o(armed_w), .reload_val_o(reload_w),
    .reload_tgl_o(tgl_w), .reason_clr_o(clr_w)
  );

  wdog_ref_cnt #(.COUNT_W(COUNT_W), .RESET_COUNT(RESET_COUNT), .SYNC_STAGES(SYNC_STAGES)) u_cnt (
    .ref_clk(ref_clk), .pin_rst_n(pin_rst_n), .armed_i(armed_w), .reload_tgl_i(tgl_w),
    .reload_val_i(reload_w), .stop_i(stop_i), .expired_o(expired_o), .cnt_o(cnt_w),
    .load_o(load_w)
  );

  wdog_reason #(.SYNC_STAGES(SYNC_STAGES)) u_reason (
    .clk(clk), .pin_rst_n(pin_rst_n), .expired_i(expired_o), .clr_i(clr_w),
    .reason_o(reason_w), .pin_ok_o(pin_ok_w), .exp_rise_o(exp_rise_w)
  );
endmodule

// File: rtl/watchdog_ctrl_chk.sv
module watchdog_ctrl_chk #(
  parameter int COUNT_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               ref_clk,
  input logic               pin_rst_n,
  input logic               armed,
  input logic [COUNT_W-1:0] reload_val,
  input logic               expired,
  input logic               stop,
  input logic               load,
  input logic [COUNT_W-1:0] cnt,
  input logic               clr,
  input logic               exp_rise,
  input logic               pin_ok,
  input logic [1:0]         reason
);
  assert_enable_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed);

  assert_reload_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    armed |=> $stable(reload_val));

  assert_expired_sticky_R8: assert property (@(posedge ref_clk) disable iff (!pin_rst_n)
    expired |=> expired);

  assert_stop_holds_R6: assert property (@(posedge ref_clk) disable iff (!pin_rst_n)
    (stop && !load) |=> $stable(cnt));

  assert_no_count_up_R6: assert property (@(posedge ref_clk) disable iff (!pin_rst_n)
    !load |=> (cnt <= $past(cnt)));

  assert_reason_legal_R9: assert property (@(posedge clk) disable iff (rst)
    reason != 2'b10);

  assert_capture_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (exp_rise && pin_ok) |=> reason == 2'b11);

  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (clr && !exp_rise && pin_ok) |=> reason == 2'b00);
endmodule

bind watchdog_ctrl watchdog_ctrl_chk #(.COUNT_W(COUNT_W)) u_chk (
  .clk(clk), .rst(rst), .ref_clk(ref_clk), .pin_rst_n(pin_rst_n), .armed(armed_w),
  .reload_val(reload_w), .expired(expired_o), .stop(stop_i), .load(load_w), .cnt(cnt_w),
  .clr(clr_w), .exp_rise(exp_rise_w), .pin_ok(pin_ok_w), .reason(reason_w)
);

// File: tb/watchdog_ctrl_tb_top.sv
module watchdog_ctrl_tb_top;
  logic        clk = 1'b0, ref_clk = 1'b0;
  logic        rst, pin_rst_n, wr_en, stop;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata, rd;
  logic        expired;
  int          n_chk = 0, n_fail = 0;
  int          ref_edges = 0;

  watchdog_ctrl dut_i (
    .clk(clk), .rst(rst), .ref_clk(ref_clk), .pin_rst_n(pin_rst_n), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .stop_i(stop), .expired_o(expired)
  );

  always #2 clk = ~clk;
  initial begin
    #3;
    forever begin ref_clk = 1'b1; #6; ref_clk = 1'b0; #6; end
  end
  always @(posedge ref_clk) ref_edges++;

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL R8 watchdog timeout: actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_win(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic full_reset();
    rst = 1'b1; pin_rst_n = 1'b0; stop = 1'b0; wr_en = 1'b0;
    repeat (12) @(negedge clk);
    pin_rst_n = 1'b1; rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic wait_ref(input int n);
    repeat (n) @(posedge ref_clk);
    @(negedge clk);
  endtask

  task automatic wait_exp(output int t);
    t = -1;
    for (int i = 0; i < 3000; i++) begin
      if (expired) begin t = ref_edges; break; end
      @(negedge clk);
    end
    if (t < 0) begin
      n_chk++; n_fail++;
      $display("FAIL R8 no expiry: actual=low expected=high");
    end
  endtask

  function automatic int exp_expiry(input int t_en, input int t_k, input int n, input bit magic);
    return (magic ? t_k : t_en) + n + 3;
  endfunction

  initial begin
    int t0, t1;
    void'($urandom(32'd777));
    addr = '0; wdata = '0;
    full_reset();

    chk("R2 expired low after pin reset", 32'(expired), 32'd0);
    bus_read(4'h8, rd); chk("R2 reason after pin reset", rd, 32'd1);
    bus_read(4'h0, rd); chk("R1 reload default", rd, 32'd32768);
    bus_read(4'h4, rd); chk("R1 control disarmed", rd, 32'd0);
    bus_read(4'hC, rd); chk("R11 unmapped offset", rd, 32'd0);

    bus_write(4'h4, 32'h0000_6699);
    bus_read(4'h4, rd); chk("R5 key while disarmed ignored", rd, 32'd0);

    bus_write(4'h0, 32'd20);
    bus_read(4'h0, rd); chk("R3 reload written while disarmed", rd, 32'd20);
    bus_write(4'h4, 32'h8000_0000); t0 = ref_edges;
    bus_read(4'h4, rd); chk("R4 armed status", rd, 32'h8000_0000);
    bus_write(4'h4, 32'h0);
    bus_read(4'h4, rd); chk("R4 cannot disarm", rd, 32'h8000_0000);
    bus_write(4'h0, 32'd99);
    bus_read(4'h0, rd); chk("R3 reload frozen when armed", rd, 32'd20);
    wait_exp(t1);
    chk_win("R8 expiry delay N=20", t1 - t0, 21, 25);
    repeat (4) @(negedge clk);
    bus_read(4'h8, rd); chk("R9 reason after expiry", rd, 32'd3);

    rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0; @(negedge clk);
    chk("R8 expiry survives bus reset", 32'(expired), 32'd1);
    bus_read(4'h4, rd); chk("R1 bus reset disarms", rd, 32'd0);
    bus_read(4'h8, rd); chk("R1 bus reset keeps reason", rd, 32'd3);
    bus_write(4'h8, 32'hFFFF_FFFF);
    bus_read(4'h8, rd); chk("R10 clear reason", rd, 32'd0);

    // R6: stop freezes the countdown
    full_reset();
    stop = 1'b1;
    bus_write(4'h0, 32'd16);
    bus_write(4'h4, 32'h8000_0000);
    wait_ref(20);
    chk("R6 no expiry while stopped", 32'(expired), 32'd0);
    stop = 1'b0; t0 = ref_edges;
    wait_exp(t1);
    chk_win("R6 countdown resumes after stop", t1 - t0, 15, 18);

    // R7: kick issued while stopped still reloads
    full_reset();
    bus_write(4'h0, 32'd30);
    bus_write(4'h4, 32'h8000_0000);
    wait_ref(20);
    stop = 1'b1;
    bus_write(4'h4, 32'h0000_6699);
    wait_ref(10);
    chk("R7 no expiry while stopped", 32'(expired), 32'd0);
    stop = 1'b0; t0 = ref_edges;
    wait_exp(t1);
    chk_win("R7 reload under stop honoured", t1 - t0, 29, 32);

    // R5: random key / non-key kicks
    for (int it = 0; it < 6; it++) begin
      int n, kick_at, t_en, t_k, e;
      bit magic;
      logic [15:0] v;
      full_reset();
      n = 10 + int'($urandom % 30);
      kick_at = 2 + int'($urandom % (n - 6));
      magic = (it < 2) ? bit'(it) : bit'($urandom % 2);
      v = 16'($urandom);
      if (v == 16'h6699) v = 16'h1234;
      if (magic) v = 16'h6699;
      bus_write(4'h0, 32'(n));
      bus_write(4'h4, 32'h8000_0000); t_en = ref_edges;
      wait_ref(kick_at);
      bus_write(4'h4, {16'h0, v}); t_k = ref_edges;
      wait_exp(t1);
      e = exp_expiry(t_en, t_k, n, magic);
      chk_win(magic ? "R5 key reloads" : "R5 non-key ignored", t1, e - 2, e + 2);
    end

    // R9/R10: clear swept across the capture edge
    for (int k = 1; k <= 5; k++) begin
      full_reset();
      bus_write(4'h0, 32'd4);
      bus_write(4'h4, 32'h8000_0000);
      wait_exp(t1);
      repeat (k - 1) @(negedge clk);
      bus_write(4'h8, 32'h0);
      repeat (2) @(negedge clk);
      bus_read(4'h8, rd);
      chk(k <= 3 ? "R9 capture wins over clear" : "R10 later clear", rd, (k <= 3) ? 32'd3 : 32'd0);
    end

    summary();
    $finish;
  end
endmodule